// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic down-counting timer with a small word-addressed register port. Software programs a reload value, selects whether the counter advances on every core clock or only on cycles where an external reference tick enable is high, and turns the timer on. The counter steps down once per active tick. When it steps from one to zero it latches a sticky count flag and, if interrupts are enabled, pulses a single pending-request output for one cycle. On the next active tick it loads the reload value again, so one period lasts reload+1 active ticks.

The register port is a plain synchronous select/write strobe interface with combinational read data. Reading the control register has a side effect: the flag bit is returned and then cleared. A write of any data to the current-value register zeroes the counter and clears the flag, which restarts the period on the next active tick. Priority handling and vectoring belong to the interrupt controller that consumes the request pulse.

Top module: `systick_timer`

## Requirements
- R1: Registers sit at byte offsets 0x10 (control/status), 0x14 (reload), 0x18 (current value) and 0x1C (calibration); a read of any other address returns zero.
- R2: Control bit 0 turns the timer on, bit 1 enables the request pulse, bit 2 picks the tick source (1 = every core clock, 0 = reference tick), bit 16 is the count flag; a write changes only bits [2:0] and every other bit reads zero.
- R3: A read of control returns the flag and clears it at that clock edge, unless an expiry happens on the same edge, in which case the flag stays set.
- R4: A write of any data to the current-value register sets the counter to zero and clears the flag; the next active tick loads the reload value.
- R5: When the counter steps from one to zero the flag sets; with bit 1 set, irq_pend is high for exactly the one cycle after that edge, and with bit 1 clear it stays low.
- R6: One period spans reload+1 active ticks: the counter reads zero for the tick on which it expires and loads the reload value on the following tick.
- R7: While the timer is off, the current-value register reads zero and the counter does not advance; turning it on again starts from zero.
- R8: With a reload value of zero the counter stays at zero and raises neither the flag nor a request.
- R9: Reload and current value are CNT_W (24) bits wide; the upper bits read as zero and written upper bits are ignored.
- R10: The calibration register returns the constant CALIB_VAL and ignores writes.
- R11: With bit 2 clear the counter advances only on cycles where ref_tick is 1; with bit 2 set it advances every cycle regardless of ref_tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Single-cycle reference tick enable |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the access cycle |
| irq_pend | output | 1 | One-cycle request pulse on expiry |

## Verification
The assertions watch, on every cycle, that the counter steps down by exactly one on each active tick above one, that it stays at zero while off or while the reload value is zero, that a request pulse never lasts two cycles and always coincides with a set flag, that a control read without a concurrent expiry leaves the flag clear, and that a current-value write empties both counter and flag. Only the bench scenarios can show the register map and bit layout, the exact period length in core-clock mode, the fact that cycles without a reference tick leave the count alone, the width masking of reload and current value, and that the calibration value is constant and write-proof.

// File: rtl/systick_pkg.sv
`timescale 1ns/1ps
package systick_pkg;

   // Byte offsets of the four word registers
   localparam int unsigned OFS_CTRL   = 32'h10;
   localparam int unsigned OFS_RELOAD = 32'h14;
   localparam int unsigned OFS_CURR   = 32'h18;
   localparam int unsigned OFS_CALIB  = 32'h1C;

   // Position of the sticky expiry flag in the control word
   localparam int unsigned FLAG_BIT   = 16;
   localparam int unsigned CTRL_BITS  = 3;

   // Writable control bits, MSB first: [2] source, [1] request enable, [0] run
   typedef struct packed {
      logic core_sel;
      logic int_en;
      logic run;
   } tmr_ctrl_t;

   typedef enum logic [2:0] {
      RS_NONE,
      RS_CTRL,
      RS_RELOAD,
      RS_CURR,
      RS_CALIB
   } reg_sel_e;

endpackage

// File: rtl/systick_tick_gen.sv
`timescale 1ns/1ps
module systick_tick_gen #(
   parameter bit EXT_TICK = 1'b1
) (
   input  logic run,
   input  logic core_sel,
   input  logic ref_tick,
   output logic tick
);

   generate
      if (EXT_TICK) begin : g_ext
         // Reference tick is only consulted when the core clock is not selected
         assign tick = run & (core_sel | ref_tick);
      end else begin : g_core_only
         logic unused_tick_in;
         assign unused_tick_in = core_sel ^ ref_tick;
         assign tick = run;
      end
   endgenerate

endmodule

// File: rtl/systick_counter.sv
`timescale 1ns/1ps
module systick_counter #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             clr,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             expire
);

   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;

   logic [CNT_W-1:0] count_q;

   // Expiry is the step from one to zero; a clearing write takes precedence
   assign expire = tick & ~clr & (count_q == CNT_ONE);
   assign count  = count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= CNT_ZERO;
      end else if (!run || clr) begin
         count_q <= CNT_ZERO;
      end else if (tick) begin
         if (count_q == CNT_ZERO) begin
            count_q <= reload;
         end else begin
            count_q <= count_q - CNT_ONE;
         end
      end
   end

   // R6: each active tick above one lowers the count by exactly one
   p_step_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !clr && count_q > CNT_ONE) |=> (count_q == $past(count_q) - CNT_ONE));

   // R7: a timer that has been off for two edges holds zero
   p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && $past(!run)) |-> (count_q == CNT_ZERO));

   // R8: a zero reload never leaves zero
   p_zero_reload_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == CNT_ZERO && reload == CNT_ZERO) |=> (count_q == CNT_ZERO));

endmodule

// File: rtl/systick_regs.sv
`timescale 1ns/1ps
module systick_regs
   import systick_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned CALIB_VAL = 32'h4000_2710
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              expire,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              run,
   output logic              int_en,
   output logic              core_sel,
   output logic [CNT_W-1:0]  reload,
   output logic              clr_cnt,
   output logic              cnt_flag,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
   localparam logic [ADDR_W-1:0] A_CURR   = ADDR_W'(OFS_CURR);
   localparam logic [ADDR_W-1:0] A_CALIB  = ADDR_W'(OFS_CALIB);
   localparam logic [DATA_W-1:0] CALIB_W  = DATA_W'(CALIB_VAL);

   reg_sel_e         sel;
   tmr_ctrl_t        ctrl_q;
   logic [CNT_W-1:0] reload_q;
   logic             flag_q;
   logic             irq_q;
   logic             wr_ctrl, wr_reload, rd_ctrl;
   logic             unused_wdata;

   assign unused_wdata = ^bus_wdata;

   always_comb begin
      sel = RS_NONE;
      if (bus_sel) begin
         unique case (bus_addr)
            A_CTRL:   sel = RS_CTRL;
            A_RELOAD: sel = RS_RELOAD;
            A_CURR:   sel = RS_CURR;
            A_CALIB:  sel = RS_CALIB;
            default:  sel = RS_NONE;
         endcase
      end
   end

   assign wr_ctrl   = bus_wr  && (sel == RS_CTRL);
   assign wr_reload = bus_wr  && (sel == RS_RELOAD);
   assign clr_cnt   = bus_wr  && (sel == RS_CURR);
   assign rd_ctrl   = !bus_wr && (sel == RS_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
         flag_q   <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q <= tmr_ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
         end
         if (wr_reload) begin
            reload_q <= bus_wdata[CNT_W-1:0];
         end
         // A fresh expiry beats the read side effect
         if (expire) begin
            flag_q <= 1'b1;
         end else if (clr_cnt || rd_ctrl) begin
            flag_q <= 1'b0;
         end
         irq_q <= expire & ctrl_q.int_en;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         unique case (sel)
            RS_CTRL: begin
               bus_rdata[CTRL_BITS-1:0] = ctrl_q;
               bus_rdata[FLAG_BIT]      = flag_q;
            end
            RS_RELOAD: bus_rdata[CNT_W-1:0] = reload_q;
            RS_CURR:   bus_rdata[CNT_W-1:0] = ctrl_q.run ? count : '0;
            RS_CALIB:  bus_rdata            = CALIB_W;
            default:   bus_rdata            = '0;
         endcase
      end
   end

   assign run      = ctrl_q.run;
   assign int_en   = ctrl_q.int_en;
   assign core_sel = ctrl_q.core_sel;
   assign reload   = reload_q;
   assign cnt_flag = flag_q;
   assign irq      = irq_q;

   // R3: a control read with no concurrent expiry leaves the flag clear
   p_flag_clear_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ctrl && !expire) |=> !flag_q);

   // R5: the request never lasts two cycles
   p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);

   // R5: a request is always accompanied by the latched flag
   p_irq_with_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> flag_q);

endmodule

// File: rtl/systick_timer.sv
`timescale 1ns/1ps
module systick_timer #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned ADDR_W    = 8,
   parameter bit          EXT_TICK  = 1'b1,
   parameter int unsigned CALIB_VAL = 32'h4000_2710
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_pend
);

   generate
      if (DATA_W < systick_pkg::FLAG_BIT + 1) begin : g_bad_data_w
         $error("DATA_W must hold the flag bit");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("CNT_W must be between 2 and DATA_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr_w
         $error("ADDR_W must reach the highest register offset");
      end
   endgenerate

   logic             run, int_en, core_sel, tick;
   logic             clr_cnt, expire, cnt_flag;
   logic [CNT_W-1:0] reload, count;
   logic             unused_int_en;

   assign unused_int_en = int_en;

   systick_regs #(
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .ADDR_W    (ADDR_W),
      .CALIB_VAL (CALIB_VAL)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .count     (count),
      .expire    (expire),
      .bus_rdata (bus_rdata),
      .run       (run),
      .int_en    (int_en),
      .core_sel  (core_sel),
      .reload    (reload),
      .clr_cnt   (clr_cnt),
      .cnt_flag  (cnt_flag),
      .irq       (irq_pend)
   );

   systick_tick_gen #(
      .EXT_TICK (EXT_TICK)
   ) u_tick (
      .run      (run),
      .core_sel (core_sel),
      .ref_tick (ref_tick),
      .tick     (tick)
   );

   systick_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .tick   (tick),
      .clr    (clr_cnt),
      .reload (reload),
      .count  (count),
      .expire (expire)
   );

   // R4: a current-value write leaves counter and flag both empty
   p_wr_curr_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cnt |=> (count == '0 && !cnt_flag));

endmodule

// File: tb/tb_systick_timer.sv
`timescale 1ns/1ps
module tb_systick_timer;

   localparam int unsigned CALIB = 32'h4000_2710;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_pend;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int irq_cnt = 0;
   int last_stamp = 0;
   int prev_stamp = 0;

   systick_timer #(.CALIB_VAL(CALIB)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_tick  (ref_tick),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_pend  (irq_pend)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (irq_pend) begin
         irq_cnt    = irq_cnt + 1;
         prev_stamp = last_stamp;
         last_stamp = cyc;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic ref_pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ref_tick = 1'b1;
         @(negedge clk); ref_tick = 1'b0;
      end
   endtask

   task automatic t_reset_state();
      logic [31:0] d;
      bus_read(8'h10, d); chk("R2 control after reset", d, 32'h0);
      bus_read(8'h14, d); chk("R1 reload after reset", d, 32'h0);
      bus_read(8'h18, d); chk("R7 current after reset", d, 32'h0);
      chk("R5 no request after reset", irq_pend, 1'b0);
   endtask

   task automatic t_map_and_calib();
      logic [31:0] d;
      bus_read(8'h1C, d); chk("R10 calibration value", d, CALIB);
      bus_write(8'h1C, 32'h0);
      bus_read(8'h1C, d); chk("R10 calibration ignores write", d, CALIB);
      bus_read(8'h20, d); chk("R1 unmapped reads zero", d, 32'h0);
      bus_read(8'h12, d); chk("R1 unaligned reads zero", d, 32'h0);
   endtask

   task automatic t_ctrl_mask();
      logic [31:0] d;
      bus_write(8'h10, 32'hFFFF_FFFF);
      bus_read(8'h10, d); chk("R2 only low three bits written", d, 32'h7);
      bus_write(8'h10, 32'h0);
      bus_write(8'h14, 32'hFFFF_FFFF);
      bus_read(8'h14, d); chk("R9 reload upper bits zero", d, 32'h00FF_FFFF);
   endtask

   task automatic t_ref_countdown();
      logic [31:0] d;
      int base;
      base = irq_cnt;
      bus_write(8'h14, 32'd3);
      bus_write(8'h10, 32'h1);
      bus_read(8'h18, d); chk("R11 no ref tick no count", d, 32'd0);
      ref_pulse(1);
      bus_read(8'h18, d); chk("R6 first tick loads reload", d, 32'd3);
      bus_read(8'h18, d); chk("R11 idle cycles hold count", d, 32'd3);
      ref_pulse(2);
      bus_read(8'h18, d); chk("R6 down to one", d, 32'd1);
      ref_pulse(1);
      bus_read(8'h18, d); chk("R6 zero on expiry tick", d, 32'd0);
      chk("R5 no request with interrupt off", irq_cnt, base);
      bus_read(8'h10, d); chk("R3 flag seen", d, 32'h0001_0001);
      bus_read(8'h10, d); chk("R3 flag cleared by read", d, 32'h1);
      ref_pulse(1);
      bus_read(8'h18, d); chk("R6 reload after zero tick", d, 32'd3);
   endtask

   task automatic t_curr_write();
      logic [31:0] d;
      ref_pulse(3);
      ref_pulse(1);
      bus_read(8'h18, d); chk("R6 second period reloads", d, 32'd3);
      bus_write(8'h18, 32'h00AB_CDEF);
      bus_read(8'h18, d); chk("R4 write clears counter", d, 32'd0);
      bus_read(8'h10, d); chk("R4 write clears flag", d, 32'h1);
      ref_pulse(1);
      bus_read(8'h18, d); chk("R4 next tick loads reload", d, 32'd3);
   endtask

   task automatic t_irq_pulse();
      logic [31:0] d;
      int base;
      bus_write(8'h10, 32'h3);
      base = irq_cnt;
      ref_pulse(3);
      @(negedge clk);
      chk("R5 one request on expiry", irq_cnt, base + 1);
      bus_read(8'h10, d); chk("R5 flag with request", d, 32'h0001_0003);
      ref_pulse(2);
      bus_read(8'h18, d); chk("R6 count after wrap", d, 32'd2);
      chk("R5 no extra request", irq_cnt, base + 1);
   endtask

   task automatic t_disable();
      logic [31:0] d;
      int base;
      base = irq_cnt;
      bus_write(8'h10, 32'h0);
      bus_read(8'h18, d); chk("R7 off reads zero", d, 32'd0);
      ref_pulse(3);
      bus_read(8'h18, d); chk("R7 off does not count", d, 32'd0);
      chk("R7 no request while off", irq_cnt, base);
      bus_write(8'h10, 32'h1);
      bus_read(8'h18, d); chk("R7 restart from zero", d, 32'd0);
      ref_pulse(1);
      bus_read(8'h18, d); chk("R7 restart loads reload", d, 32'd3);
   endtask

   task automatic t_zero_reload();
      logic [31:0] d;
      int base;
      bus_write(8'h14, 32'd0);
      bus_write(8'h18, 32'd0);
      bus_write(8'h10, 32'h3);
      base = irq_cnt;
      ref_pulse(4);
      bus_read(8'h18, d); chk("R8 stays at zero", d, 32'd0);
      bus_read(8'h10, d); chk("R8 no flag", d, 32'h3);
      chk("R8 no request", irq_cnt, base);
   endtask

   task automatic t_full_width();
      logic [31:0] d;
      bus_write(8'h10, 32'h1);
      bus_write(8'h14, 32'hA5FF_FFFF);
      bus_write(8'h18, 32'd0);
      ref_pulse(1);
      bus_read(8'h18, d); chk("R9 full count value", d, 32'h00FF_FFFF);
      ref_pulse(1);
      bus_read(8'h18, d); chk("R9 step below max", d, 32'h00FF_FFFE);
      bus_write(8'h10, 32'h0);
   endtask

   task automatic t_core_period();
      logic [31:0] d;
      int base;
      int guard;
      bus_write(8'h14, 32'd4);
      bus_write(8'h18, 32'd0);
      base = irq_cnt;
      ref_tick = 1'b0;
      bus_write(8'h10, 32'h7);
      guard = 0;
      while (irq_cnt < base + 2 && guard < 100) begin
         @(negedge clk); #1;
         guard++;
      end
      chk("R11 core clock counts without ref tick", irq_cnt >= base + 2, 1'b1);
      chk("R6 period is reload plus one", last_stamp - prev_stamp, 32'd5);
      bus_read(8'h10, d); chk("R3 flag in core mode", d, 32'h0001_0007);
      bus_write(8'h10, 32'h0);
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_map_and_calib();
      t_ctrl_mask();
      t_ref_countdown();
      t_curr_write();
      t_irq_pulse();
      t_disable();
      t_zero_reload();
      t_full_width();
      t_core_period();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule